// File: doc/BRIEF.md
# SMBus Bus Timing Monitor

This block watches the two wires of an SMBus segment (clock and data) without driving them. Both lines are brought into a fast system clock domain and edge-detected. Every data edge is then classified as a start condition, a stop condition or an ordinary data transition. Free-running interval counters record how many system cycles have passed since each kind of reference event. Whenever an event closes a timed interval, the interval is compared with a minimum limit.

When a minimum is broken, the flag for that rule is set and stays set until software-independent logic asserts the synchronous clear. A one-cycle pulse on a per-rule output marks the moment of the breach. All limits are given in nanoseconds and converted to system cycles by rounding up from the clock-frequency parameter. The data-hold rule follows a mode input: it uses a 300 ns minimum for SMBus and has no minimum for plain I2C.

The monitor sits beside a bus interface or a bus port during bring-up and in operation. It flags peers or local masters that run the bus faster than the protocol allows.

Top module: `smb_timing_monitor`

## Requirements
- R1: After reset, both lines are treated as idle high, and all of `viol_flags` and `viol_pulse` read 0.
- R2: A data edge is decoded as a start when data falls, or a stop when data rises, only if the clock was high both before and after that edge. Any other data edge is a data transition. At most one of these three events occurs per cycle.
- R3: Bit 0 (bus gap) is set when a start occurs fewer than ceil(4700 ns) cycles after the most recent stop. This rule is armed only once a stop has been seen since reset.
- R4: Bit 1 (start lead) is set when the first clock falling edge after a start or repeated start comes fewer than ceil(4000 ns) cycles after that start.
- R5: Bit 2 (restart setup) is set when a start occurs fewer than ceil(4700 ns) cycles after the most recent clock rising edge. This rule is armed only once a clock rising edge has been seen since reset.
- R6: Bit 3 (stop setup) is set when a stop occurs fewer than ceil(4000 ns) cycles after the most recent clock rising edge.
- R7: Bit 4 (data setup) is set when a clock rising edge follows a data transition made in the same clock-low phase by fewer than ceil(250 ns) cycles.
- R8: Bit 5 (data hold) is set when `smbus_mode` is 1 and the first data transition after a clock falling edge comes fewer than ceil(300 ns) cycles after it. When `smbus_mode` is 0, bit 5 is never set.
- R9: A rule breach raises the matching bit of `viol_pulse` for exactly one cycle and sets the matching bit of `viol_flags`. The flag bit stays set across later compliant traffic. A line change shows up on the outputs on the third rising clock edge after it.
- R10: `clr` high at a rising edge leaves `viol_flags` equal to the breaches detected in that same cycle only, which is 0 on a quiet bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Raw bus clock line, asynchronous |
| sda_in | input | 1 | Raw bus data line, asynchronous |
| smbus_mode | input | 1 | 1: 300 ns data hold minimum; 0: no hold minimum |
| clr | input | 1 | Synchronous clear of all sticky flags |
| viol_flags | output | 6 | Sticky per-rule breach flags, bit map as in R3 to R8 |
| viol_pulse | output | 6 | One-cycle per-rule breach strobes |

## Verification
The bench drives whole frames: start, a data bit, a repeated start, and a stop. Each interval is placed either exactly at its limit or one cycle short. A design with an off-by-one counter or a `<=` compare would flag the compliant frames or miss the short ones. The first frame after reset uses a tiny gap and has no earlier clock rise, so a monitor that arms its gap or restart checks from reset would raise bits 0 and 2 falsely. Other frames cover the following cases:
- A short gap after a long stop setup, so the restart setup window spans the stop and catches designs that reset the wrong counter.
- A short hold in I2C mode, which must stay silent.
- Two breaches left uncleared across a compliant frame, which exposes flags that are not sticky and pulse counts that double-fire.

// File: rtl/smb_mon_pkg.sv
package smb_mon_pkg;

  // Minimum bus timings in nanoseconds
  localparam int unsigned NS_GAP      = 4700;  // stop -> next start
  localparam int unsigned NS_LEAD     = 4000;  // start -> first clock fall
  localparam int unsigned NS_RS_SU    = 4700;  // clock rise -> start
  localparam int unsigned NS_P_SU     = 4000;  // clock rise -> stop
  localparam int unsigned NS_D_SU     = 250;   // data transition -> clock rise
  localparam int unsigned NS_D_HD_SMB = 300;   // clock fall -> data transition

  // Rule bit positions in the flag vectors
  localparam int NRULES      = 6;
  localparam int RULE_GAP    = 0;
  localparam int RULE_LEAD   = 1;
  localparam int RULE_RS_SU  = 2;
  localparam int RULE_P_SU   = 3;
  localparam int RULE_D_SU   = 4;
  localparam int RULE_D_HD   = 5;

  // Reference events that own an interval counter
  localparam int NCNT      = 5;
  localparam int CNT_STOP  = 0;
  localparam int CNT_START = 1;
  localparam int CNT_RISE  = 2;
  localparam int CNT_FALL  = 3;
  localparam int CNT_DCHG  = 4;

  // ceil(ns * f) with f given in kHz
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_khz);
    longint unsigned prod;
    prod = longint'(ns) * longint'(clk_khz);
    return int'((prod + 64'd999_999) / 64'd1_000_000);
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic level,
  output logic prev_level,
  output logic rise,
  output logic fall
);
  // sh[0..STAGES-1] is the synchronizer; sh[STAGES] holds the prior sample
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-1:0], line_in};
  end

  assign level      = sh[STAGES-1];
  assign prev_level = sh[STAGES];
  assign rise       = level & ~prev_level;
  assign fall       = ~level & prev_level;

  assert_edge_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise, fall}));

endmodule

// File: rtl/smb_cond_decode.sv
module smb_cond_decode (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_lvl,
  input  logic scl_prev,
  input  logic sda_rise,
  input  logic sda_fall,
  output logic ev_start,
  output logic ev_stop,
  output logic ev_dchg
);
  logic scl_steady_high;

  always_comb begin
    scl_steady_high = scl_lvl & scl_prev;
    ev_start = sda_fall & scl_steady_high;
    ev_stop  = sda_rise & scl_steady_high;
    ev_dchg  = (sda_rise | sda_fall) & ~scl_steady_high;
  end

  assert_one_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_start, ev_stop, ev_dchg}));

  assert_cond_needs_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start | ev_stop) |-> (scl_lvl && $stable(scl_lvl)));

endmodule

// File: rtl/smb_gap_counter.sv
module smb_gap_counter #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  output logic [W-1:0] count
);
  // Reset to saturation: an event never seen looks infinitely old
  localparam logic [W-1:0] SAT = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)            count <= SAT;
    else if (restart)      count <= W'(1);
    else if (count != SAT) count <= count + W'(1);
  end

  assert_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (count == W'(1)));

  assert_saturate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && count == SAT) |=> (count == SAT));

endmodule

// File: rtl/smb_rule_flags.sv
module smb_rule_flags #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [N-1:0] hit,
  output logic [N-1:0] flags,
  output logic [N-1:0] pulse
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
      pulse <= '0;
    end else begin
      pulse <= hit;
      flags <= clr ? hit : (flags | hit);
    end
  end

  assert_pulse_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((pulse & ~flags) == '0));

  assert_flags_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((flags & $past(flags)) == $past(flags)));

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (flags == pulse));

endmodule

// File: rtl/smb_timing_monitor.sv
module smb_timing_monitor
  import smb_mon_pkg::*;
#(
  parameter int unsigned CLK_KHZ     = 100_000,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              smbus_mode,
  input  logic              clr,
  output logic [NRULES-1:0] viol_flags,
  output logic [NRULES-1:0] viol_pulse
);
  localparam int unsigned T_GAP   = ns_to_cyc(NS_GAP, CLK_KHZ);
  localparam int unsigned T_LEAD  = ns_to_cyc(NS_LEAD, CLK_KHZ);
  localparam int unsigned T_RS_SU = ns_to_cyc(NS_RS_SU, CLK_KHZ);
  localparam int unsigned T_P_SU  = ns_to_cyc(NS_P_SU, CLK_KHZ);
  localparam int unsigned T_D_SU  = ns_to_cyc(NS_D_SU, CLK_KHZ);
  localparam int unsigned T_D_HD  = ns_to_cyc(NS_D_HD_SMB, CLK_KHZ);
  localparam int unsigned T_MAX   = max2(max2(max2(T_GAP, T_LEAD), max2(T_RS_SU, T_P_SU)),
                                         max2(T_D_SU, T_D_HD));
  localparam int          CW      = $clog2(T_MAX + 2);

  localparam logic [CW-1:0] L_GAP   = CW'(T_GAP);
  localparam logic [CW-1:0] L_LEAD  = CW'(T_LEAD);
  localparam logic [CW-1:0] L_RS_SU = CW'(T_RS_SU);
  localparam logic [CW-1:0] L_P_SU  = CW'(T_P_SU);
  localparam logic [CW-1:0] L_D_SU  = CW'(T_D_SU);
  localparam logic [CW-1:0] L_D_HD  = CW'(T_D_HD);

  // ---- synchronize and edge-detect both lines ----
  logic [1:0] raw_in, lvl, prv, rse, fal;
  assign raw_in = {sda_in, scl_in};

  for (genvar g = 0; g < 2; g++) begin : g_line
    smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .line_in(raw_in[g]),
      .level(lvl[g]), .prev_level(prv[g]), .rise(rse[g]), .fall(fal[g])
    );
  end

  logic scl_lvl, scl_prev, scl_rise, scl_fall, sda_rise, sda_fall;
  assign scl_lvl  = lvl[0];
  assign scl_prev = prv[0];
  assign scl_rise = rse[0];
  assign scl_fall = fal[0];
  assign sda_rise = rse[1];
  assign sda_fall = fal[1];

  // ---- bus condition decoding ----
  logic ev_start, ev_stop, ev_dchg;
  smb_cond_decode u_dec (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .scl_prev(scl_prev),
    .sda_rise(sda_rise), .sda_fall(sda_fall),
    .ev_start(ev_start), .ev_stop(ev_stop), .ev_dchg(ev_dchg)
  );

  // ---- interval counters, one per reference event ----
  logic [NCNT-1:0] restart;
  logic [CW-1:0]   since [NCNT];

  always_comb begin
    restart            = '0;
    restart[CNT_STOP]  = ev_stop;
    restart[CNT_START] = ev_start;
    restart[CNT_RISE]  = scl_rise;
    restart[CNT_FALL]  = scl_fall;
    restart[CNT_DCHG]  = ev_dchg;
  end

  for (genvar c = 0; c < NCNT; c++) begin : g_cnt
    smb_gap_counter #(.W(CW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .restart(restart[c]), .count(since[c])
    );
  end

  // ---- phase bookkeeping: which check the next edge closes ----
  logic lead_pend;   // start seen, first clock fall not yet
  logic dsu_pend;    // data transition seen in this clock-low phase
  logic dhd_pend;    // clock fell, no data transition yet

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lead_pend <= 1'b0;
      dsu_pend  <= 1'b0;
      dhd_pend  <= 1'b0;
    end else begin
      if (ev_start)      lead_pend <= 1'b1;
      else if (scl_fall) lead_pend <= 1'b0;

      if (ev_dchg)                  dsu_pend <= 1'b1;
      else if (scl_rise | scl_fall) dsu_pend <= 1'b0;

      if (scl_fall)     dhd_pend <= 1'b1;
      else if (ev_dchg) dhd_pend <= 1'b0;
    end
  end

  // ---- rule evaluation ----
  logic [CW-1:0]     hold_lim;
  logic [NRULES-1:0] hit;

  always_comb begin
    hold_lim = smbus_mode ? L_D_HD : '0;
    hit = '0;
    hit[RULE_GAP]   = ev_start && (since[CNT_STOP] < L_GAP);
    hit[RULE_LEAD]  = scl_fall && lead_pend && (since[CNT_START] < L_LEAD);
    hit[RULE_RS_SU] = ev_start && (since[CNT_RISE] < L_RS_SU);
    hit[RULE_P_SU]  = ev_stop && (since[CNT_RISE] < L_P_SU);
    hit[RULE_D_SU]  = scl_rise && dsu_pend && (since[CNT_DCHG] < L_D_SU);
    hit[RULE_D_HD]  = ev_dchg && dhd_pend && (since[CNT_FALL] < hold_lim);
  end

  smb_rule_flags #(.N(NRULES)) u_flags (
    .clk(clk), .rst_n(rst_n), .clr(clr), .hit(hit),
    .flags(viol_flags), .pulse(viol_pulse)
  );

  assert_i2c_no_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !smbus_mode |-> !hit[RULE_D_HD]);

  assert_stop_setup_on_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit[RULE_P_SU] |-> (sda_rise && scl_lvl));

  assert_lead_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit[RULE_LEAD] |-> (scl_prev && !scl_lvl));

endmodule

// File: tb/smb_timing_monitor_bench.sv
module smb_timing_monitor_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_in = 1'b1;
  logic       sda_in = 1'b1;
  logic       smbus_mode = 1'b1;
  logic       clr = 1'b0;
  logic [5:0] viol_flags, viol_pulse;

  always #5 clk = ~clk;   // 100 MHz

  smb_timing_monitor u_smb_timing_monitor (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .smbus_mode(smbus_mode), .clr(clr),
    .viol_flags(viol_flags), .viol_pulse(viol_pulse)
  );

  // limits restated: 10 ns period, round up
  function automatic int cyc(input int ns);
    return (ns + 9) / 10;
  endfunction

  int checks = 0, errors = 0;
  int pulse_total = 0;
  bit done = 0;

  always @(negedge clk) if (rst_n) pulse_total += $countones(viol_pulse);

  typedef struct {
    logic [5:0] flags;
    int         npulse;
    int         base;
    string      tag;
  } item_t;
  item_t sbq[$];
  event chk_ev;

  // monitor: pops expectations and compares
  initial begin
    forever begin
      @(chk_ev);
      while (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        checks++;
        if (viol_flags !== it.flags) begin
          errors++;
          $display("FAIL %s flags: actual %b expected %b", it.tag, viol_flags, it.flags);
        end
        checks++;
        if ((pulse_total - it.base) != it.npulse) begin
          errors++;
          $display("FAIL %s pulses: actual %0d expected %0d", it.tag, pulse_total - it.base, it.npulse);
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // bench model of the bus history
  bit         stop_seen = 0, rise_seen = 0;
  int         last_psu = 0;
  logic [5:0] acc = '0;
  localparam int PAD = 8;

  task automatic frame(input string tag, input bit mode, input int gap, input int lead,
                       input int dhd, input int dsu, input int rssu, input int psu,
                       input bit do_clr);
    logic [5:0] f;
    int n, base;
    f = '0; n = 0;
    if (stop_seen && gap < cyc(4700))               begin f[0] = 1; n++; end
    if (rise_seen && (last_psu + gap) < cyc(4700))  begin f[2] = 1; n++; end
    if (lead < cyc(4000))                           begin f[1] = 1; n++; end
    if (mode && dhd < cyc(300))                     begin f[5] = 1; n++; end
    if (dsu < cyc(250))                             begin f[4] = 1; n++; end
    if (rssu < cyc(4700))                           begin f[2] = 1; n++; end
    if (psu < cyc(4000))                            begin f[3] = 1; n++; end
    acc |= f;

    smbus_mode = mode;
    base = pulse_total;
    step(gap - PAD);
    sda_in = 1'b0;            // start
    step(lead);  scl_in = 1'b0;
    step(dhd);   sda_in = 1'b1;  // data bit 1
    step(dsu);   scl_in = 1'b1;
    step(rssu);  sda_in = 1'b0;  // repeated start
    step(500);   scl_in = 1'b0;
    step(100);   scl_in = 1'b1;
    step(psu);   sda_in = 1'b1;  // stop
    step(6);
    sbq.push_back('{flags: acc, npulse: n, base: base, tag: tag});
    ->chk_ev;
    stop_seen = 1; rise_seen = 1; last_psu = psu;
    if (do_clr) begin
      clr = 1'b1; acc = '0;
    end
    step(1);
    clr = 1'b0;
    step(1);
  endtask

  initial begin
    step(4);
    // R1: reset state
    checks++;
    if (viol_flags !== 6'b0 || viol_pulse !== 6'b0) begin
      errors++;
      $display("FAIL R1 reset: actual %b/%b expected 000000/000000", viol_flags, viol_pulse);
    end
    rst_n = 1'b1;
    step(2);

    // R3 R5 arming: tiny gap, no prior stop or clock rise
    frame("R3_R5 unarmed first frame", 1, PAD, 450, 40, 30, 500, 450, 1);
    // every interval exactly at its limit
    frame("R2 R4 R6 R7 R8 at-limit frame", 1, 470, 400, 30, 25, 470, 400, 1);
    frame("R3 gap one short", 1, 469, 450, 40, 30, 500, 450, 1);
    frame("R4 lead one short", 1, 500, 399, 40, 30, 500, 450, 1);
    frame("R5 restart setup one short", 1, 500, 450, 40, 30, 469, 450, 1);
    frame("R6 stop setup one short", 1, 500, 450, 40, 30, 500, 399, 1);
    frame("R7 data setup one short", 1, 470, 450, 40, 24, 500, 450, 1);
    frame("R8 hold one short smbus", 1, 500, 450, 29, 30, 500, 450, 1);
    frame("R8 short hold ignored i2c", 0, 500, 450, 1, 30, 500, 450, 1);
    // R3 + R5: short gap after long stop setup, rise-to-start window spans stop
    frame("R3_R5 short gap", 1, 50, 450, 40, 30, 500, 450, 1);
    // R9: two breaches, kept without clear across a compliant frame
    frame("R9 two breaches", 1, 500, 10, 40, 10, 500, 450, 0);
    frame("R9 sticky across compliant", 1, 500, 450, 40, 30, 500, 450, 1);
    // R10: flags empty after the clear
    step(2);
    checks++;
    if (viol_flags !== 6'b0) begin
      errors++;
      $display("FAIL R10 clear: actual %b expected 000000", viol_flags);
    end
    frame("R10 clean after clear", 1, 500, 450, 40, 30, 500, 450, 1);
    step(4);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule